// File: doc/BRIEF.md
# GF(8) Hard Decision and Syndrome Check

This block closes one decoding iteration of a short non-binary low-density parity-check code over GF(8). For each variable node, one cycle carries the node's channel likelihood vector and its incoming check-to-variable vectors. The block multiplies them element by element to form the a-posteriori vector. It takes the position with the largest value as a 3-bit index and converts that index into a polynomial-basis GF(8) symbol, which it stores in arrival order. The decision does not depend on a common scale factor, so the division that would normalise the vector to unit sum is left out.

Once the last variable node of the frame has been accepted, the block evaluates the parity-check rows one per cycle. Each row is described by a short list of (column, coefficient) pairs. The row multiplies each addressed symbol by its coefficient in GF(8) and combines the products with XOR. After the last row, the block pulses a completion flag, reports whether every row was zero, advances an iteration counter, and raises a stop flag when the syndrome is zero or the iteration limit has been reached. A start pulse begins a new codeword.

Top module: `gf8_hard_syndrome`

## Requirements
- R1: After reset, stop_o, iter_done_o and syn_zero_o are 0, iter_cnt_o is 0 and every symbol in sym_o is 0. vn_valid_i has no effect until start_i has been seen.
- R2: For each accepted variable node the block forms, for every position k in 0..7, the product of the channel value in chan_i[k*LW +: LW] and the DV message values in msg_i[(d*8+k)*LW +: LW]. It decides on the position with the largest product.
- R3: When several positions share the largest product, the lowest position wins.
- R4: Position 0 maps to symbol 0, and position k (1..7) maps to alpha^(k-1). Symbols use polynomial basis modulo x^3+x+1, with bit i holding the coefficient of alpha^i, which gives positions 0..7 the symbols 0,1,2,4,3,6,7,5.
- R5: The n-th variable node accepted after a start or after the previous completion is stored as symbol n and appears on sym_o[3n+2:3n].
- R6: Check row r uses entries j in 0..DC-1, with a column index in h_col_i[(r*DC+j)*COLW +: COLW] and a coefficient in h_coef_i[(r*DC+j)*3 +: 3]. Its syndrome is the XOR of coefficient times symbol under GF(8) multiplication, and an entry whose coefficient is 0 contributes nothing. syn_zero_o is 1 after a completion exactly when every row was zero, and it holds that value until the next completion or start.
- R7: iter_done_o is a one-cycle pulse. It appears N_CHK cycles after the cycle in which the last variable node of the frame is accepted, which is one cycle after the last row is evaluated.
- R8: Each completion increments iter_cnt_o. At that completion stop_o rises if the syndrome is zero or if the new count is at least max_iter_i, so a limit of 0 stops after the first iteration. stop_o stays high until start_i.
- R9: start_i clears iter_cnt_o, stop_o and syn_zero_o and begins collecting at symbol 0. It takes precedence over a vn_valid_i in the same cycle and over a row evaluation in progress, which is abandoned without iter_done_o.
- R10: vn_valid_i is ignored while rows are being evaluated and while stopped, and the stored symbols stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new codeword; clears count and flags |
| max_iter_i | input | CNT_W (8) | Iteration limit |
| vn_valid_i | input | 1 | One variable node's vectors are present |
| chan_i | input | 8*LW (32) | Channel likelihood vector, position k at k*LW |
| msg_i | input | DV*8*LW (64) | Incoming check messages, message d position k at (d*8+k)*LW |
| h_col_i | input | N_CHK*DC*COLW (36) | Column index of each row entry |
| h_coef_i | input | N_CHK*DC*3 (36) | GF(8) coefficient of each row entry |
| sym_o | output | N_VN*3 (18) | Decided symbols, symbol n at bits 3n+2:3n |
| iter_done_o | output | 1 | One-cycle pulse at the end of an iteration |
| syn_zero_o | output | 1 | All rows were zero at the last completion |
| stop_o | output | 1 | Decoding halted |
| iter_cnt_o | output | CNT_W (8) | Iterations completed since start |

## Verification
Two things can land on the same clock edge. A start pulse can arrive on the edge where the final row would complete, and a start pulse can arrive together with a variable-node strobe. The bench provokes the first by raising start exactly N_CHK-1 cycles after the last node and then confirming that no completion pulse follows and that count and stop read zero. It provokes the second by presenting a strongly biased node with start and confirming that symbol 0 keeps its old value. It also holds the strobe high with different data through the evaluation window and confirms that the stored symbols are untouched when the completion pulse arrives.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  localparam int GF_M = 3;
  localparam int GF_Q = 8;

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EVAL    = 2'd2
  } hs_state_e;

  // power of alpha -> polynomial basis (x^3 + x + 1)
  function automatic gf_t gf_antilog(input logic [2:0] e);
    gf_t r;
    case (e)
      3'd0:    r = 3'd1;
      3'd1:    r = 3'd2;
      3'd2:    r = 3'd4;
      3'd3:    r = 3'd3;
      3'd4:    r = 3'd6;
      3'd5:    r = 3'd7;
      3'd6:    r = 3'd5;
      default: r = 3'd1;
    endcase
    return r;
  endfunction

  // polynomial basis -> power of alpha (0 maps to 0, caller masks)
  function automatic logic [2:0] gf_log(input gf_t a);
    logic [2:0] r;
    case (a)
      3'd1:    r = 3'd0;
      3'd2:    r = 3'd1;
      3'd4:    r = 3'd2;
      3'd3:    r = 3'd3;
      3'd6:    r = 3'd4;
      3'd7:    r = 3'd5;
      3'd5:    r = 3'd6;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  // vector position -> field symbol: 0 is zero, k is alpha^(k-1)
  function automatic gf_t pos_to_sym(input logic [2:0] p);
    gf_t r;
    if (p == 3'd0) r = '0;
    else           r = gf_antilog(p - 3'd1);
    return r;
  endfunction
endpackage

// File: rtl/hs_gf8_mul.sv
`timescale 1ns/1ps
module hs_gf8_mul
  import hs_pkg::*;
(
  input  gf_t a_i,
  input  gf_t b_i,
  output gf_t p_o
);
  logic [3:0] log_sum;
  logic [2:0] log_mod;

  always_comb begin
    log_sum = {1'b0, gf_log(a_i)} + {1'b0, gf_log(b_i)};
    if (log_sum >= 4'd7) log_mod = 3'(log_sum - 4'd7);
    else                 log_mod = log_sum[2:0];
    if ((a_i == '0) || (b_i == '0)) p_o = '0;
    else                            p_o = gf_antilog(log_mod);
  end
endmodule

// File: rtl/hs_app_decide.sv
`timescale 1ns/1ps
module hs_app_decide
  import hs_pkg::*;
#(
  parameter int LW = 4,
  parameter int DV = 2
)(
  input  logic [GF_Q*LW-1:0]    chan_i,
  input  logic [DV*GF_Q*LW-1:0] msg_i,
  output gf_t                   sym_o
);
  localparam int PW = LW * (DV + 1);

  logic [GF_Q*PW-1:0] app_flat;
  logic [PW-1:0]      best_val;
  logic [2:0]         best_pos;

  // a-posteriori product per position (scale omitted: argmax is invariant)
  for (genvar k = 0; k < GF_Q; k++) begin : g_pos
    logic [PW-1:0] part [DV+1];
    assign part[0] = PW'(chan_i[k*LW +: LW]);
    for (genvar d = 0; d < DV; d++) begin : g_msg
      assign part[d+1] = part[d] * PW'(msg_i[(d*GF_Q+k)*LW +: LW]);
    end
    assign app_flat[k*PW +: PW] = part[DV];
  end

  // linear scan; strict compare keeps the lowest position on ties
  always_comb begin
    best_val = app_flat[0 +: PW];
    best_pos = 3'd0;
    for (int k = 1; k < GF_Q; k++) begin
      if (app_flat[k*PW +: PW] > best_val) begin
        best_val = app_flat[k*PW +: PW];
        best_pos = 3'(k);
      end
    end
  end

  // binary index -> field symbol
  assign sym_o = pos_to_sym(best_pos);
endmodule

// File: rtl/hs_row_syn.sv
`timescale 1ns/1ps
module hs_row_syn
  import hs_pkg::*;
#(
  parameter int N_VN = 6,
  parameter int DC   = 4,
  parameter int COLW = 3
)(
  input  logic [N_VN*GF_M-1:0] syms_i,
  input  logic [DC*COLW-1:0]   cols_i,
  input  logic [DC*GF_M-1:0]   coefs_i,
  output gf_t                  syn_o
);
  logic [DC*GF_M-1:0] prod_flat;

  for (genvar j = 0; j < DC; j++) begin : g_ent
    gf_t pick;
    always_comb begin
      pick = '0;
      for (int v = 0; v < N_VN; v++) begin
        if (cols_i[j*COLW +: COLW] == COLW'(v)) pick = syms_i[v*GF_M +: GF_M];
      end
    end
    hs_gf8_mul u_mul (
      .a_i (coefs_i[j*GF_M +: GF_M]),
      .b_i (pick),
      .p_o (prod_flat[j*GF_M +: GF_M])
    );
  end

  always_comb begin
    syn_o = '0;
    for (int j = 0; j < DC; j++) syn_o = syn_o ^ prod_flat[j*GF_M +: GF_M];
  end
endmodule

// File: rtl/hs_iter_ctrl.sv
`timescale 1ns/1ps
module hs_iter_ctrl
  import hs_pkg::*;
#(
  parameter int N_VN  = 6,
  parameter int N_CHK = 3,
  parameter int CNT_W = 8,
  parameter int PTRW  = 3,
  parameter int ROWW  = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vn_valid_i,
  input  logic             row_zero_i,
  input  logic [CNT_W-1:0] max_iter_i,
  output logic             wr_en_o,
  output logic [PTRW-1:0]  vn_ptr_o,
  output logic [ROWW-1:0]  row_idx_o,
  output logic             iter_done_o,
  output logic             syn_zero_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] iter_cnt_o
);
  hs_state_e        state_q, state_d;
  logic [PTRW-1:0]  ptr_q, ptr_d;
  logic [ROWW-1:0]  row_q, row_d;
  logic             zacc_q, zacc_d;
  logic             done_q, done_d;
  logic             synz_q, synz_d;
  logic             stop_q, stop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign wr_en_o = (state_q == ST_COLLECT) && vn_valid_i && !start_i;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    row_d   = row_q;
    zacc_d  = zacc_q;
    done_d  = 1'b0;
    synz_d  = synz_q;
    stop_d  = stop_q;
    cnt_d   = cnt_q;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    if (start_i) begin
      state_d = ST_COLLECT;
      ptr_d   = '0;
      row_d   = '0;
      zacc_d  = 1'b1;
      synz_d  = 1'b0;
      stop_d  = 1'b0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (vn_valid_i) begin
            if (ptr_q == PTRW'(N_VN-1)) begin
              state_d = ST_EVAL;
              ptr_d   = '0;
              row_d   = '0;
              zacc_d  = 1'b1;
            end else begin
              ptr_d = ptr_q + 1'b1;
            end
          end
        end
        ST_EVAL: begin
          zacc_d = zacc_q & row_zero_i;
          if (row_q == ROWW'(N_CHK-1)) begin
            done_d  = 1'b1;
            synz_d  = zacc_q & row_zero_i;
            cnt_d   = cnt_inc[CNT_W] ? '1 : cnt_inc[CNT_W-1:0];
            stop_d  = synz_d || (cnt_inc >= {1'b0, max_iter_i});
            state_d = stop_d ? ST_IDLE : ST_COLLECT;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
        ST_IDLE: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      row_q   <= '0;
      zacc_q  <= 1'b1;
      done_q  <= 1'b0;
      synz_q  <= 1'b0;
      stop_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      row_q   <= row_d;
      zacc_q  <= zacc_d;
      done_q  <= done_d;
      synz_q  <= synz_d;
      stop_q  <= stop_d;
      cnt_q   <= cnt_d;
    end
  end

  assign vn_ptr_o    = ptr_q;
  assign row_idx_o   = row_q;
  assign iter_done_o = done_q;
  assign syn_zero_o  = synz_q;
  assign stop_o      = stop_q;
  assign iter_cnt_o  = cnt_q;
endmodule

// File: rtl/gf8_hard_syndrome.sv
`timescale 1ns/1ps
module gf8_hard_syndrome
  import hs_pkg::*;
#(
  parameter int N_VN  = 6,
  parameter int N_CHK = 3,
  parameter int DC    = 4,
  parameter int LW    = 4,
  parameter int DV    = 2,
  parameter int CNT_W = 8,
  parameter int COLW  = (N_VN > 1) ? $clog2(N_VN) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [CNT_W-1:0]          max_iter_i,
  input  logic                      vn_valid_i,
  input  logic [GF_Q*LW-1:0]        chan_i,
  input  logic [DV*GF_Q*LW-1:0]     msg_i,
  input  logic [N_CHK*DC*COLW-1:0]  h_col_i,
  input  logic [N_CHK*DC*GF_M-1:0]  h_coef_i,
  output logic [N_VN*GF_M-1:0]      sym_o,
  output logic                      iter_done_o,
  output logic                      syn_zero_o,
  output logic                      stop_o,
  output logic [CNT_W-1:0]          iter_cnt_o
);
  localparam int PTRW   = (N_VN > 1) ? $clog2(N_VN) : 1;
  localparam int ROWW   = (N_CHK > 1) ? $clog2(N_CHK) : 1;
  localparam int ROW_CW = DC * COLW;
  localparam int ROW_VW = DC * GF_M;

  gf_t                 dec_sym;
  logic                wr_en;
  logic [PTRW-1:0]     vn_ptr;
  logic [ROWW-1:0]     row_idx;
  logic [N_VN*GF_M-1:0] sym_q;
  logic [ROW_CW-1:0]   row_cols;
  logic [ROW_VW-1:0]   row_coefs;
  gf_t                 row_syn;
  logic                row_zero;

  hs_app_decide #(.LW(LW), .DV(DV)) u_decide (
    .chan_i (chan_i),
    .msg_i  (msg_i),
    .sym_o  (dec_sym)
  );

  // symbol store, written in arrival order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '0;
    end else if (wr_en) begin
      sym_q[vn_ptr*GF_M +: GF_M] <= dec_sym;
    end
  end

  assign row_cols  = h_col_i[row_idx*ROW_CW +: ROW_CW];
  assign row_coefs = h_coef_i[row_idx*ROW_VW +: ROW_VW];

  hs_row_syn #(.N_VN(N_VN), .DC(DC), .COLW(COLW)) u_row (
    .syms_i  (sym_q),
    .cols_i  (row_cols),
    .coefs_i (row_coefs),
    .syn_o   (row_syn)
  );

  assign row_zero = (row_syn == '0);

  hs_iter_ctrl #(
    .N_VN(N_VN), .N_CHK(N_CHK), .CNT_W(CNT_W), .PTRW(PTRW), .ROWW(ROWW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .vn_valid_i  (vn_valid_i),
    .row_zero_i  (row_zero),
    .max_iter_i  (max_iter_i),
    .wr_en_o     (wr_en),
    .vn_ptr_o    (vn_ptr),
    .row_idx_o   (row_idx),
    .iter_done_o (iter_done_o),
    .syn_zero_o  (syn_zero_o),
    .stop_o      (stop_o),
    .iter_cnt_o  (iter_cnt_o)
  );

  assign sym_o = sym_q;
endmodule

// File: rtl/gf8_hard_syndrome_chk.sv
`timescale 1ns/1ps
module gf8_hard_syndrome_chk #(
  parameter int SYMW  = 18,
  parameter int CNT_W = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             vn_valid_i,
  input logic [SYMW-1:0]  sym_o,
  input logic             iter_done_o,
  input logic             syn_zero_o,
  input logic             stop_o,
  input logic [CNT_W-1:0] iter_cnt_o
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done_o |=> !iter_done_o);

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done_o |-> (iter_cnt_o == $past(iter_cnt_o) + 1'b1));

  p_stop_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_o) |-> iter_done_o);

  p_zero_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_o && syn_zero_o) |-> stop_o);

  p_stop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !start_i) |=> stop_o);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!stop_o && !iter_done_o && !syn_zero_o && (iter_cnt_o == '0)));

  p_idle_sym_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vn_valid_i || stop_o || start_i) |=> $stable(sym_o));
endmodule

bind gf8_hard_syndrome gf8_hard_syndrome_chk #(
  .SYMW(N_VN*3), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .vn_valid_i  (vn_valid_i),
  .sym_o       (sym_o),
  .iter_done_o (iter_done_o),
  .syn_zero_o  (syn_zero_o),
  .stop_o      (stop_o),
  .iter_cnt_o  (iter_cnt_o)
);

// File: tb/gf8_hard_syndrome_tb.sv
`timescale 1ns/1ps
module gf8_hard_syndrome_tb;
  localparam int NV = 6, NC = 3, DC = 4, LW = 4, DV = 2, Q = 8, COLW = 3;

  logic clk = 1'b0;
  logic rst_n, start_i, vn_valid_i;
  logic [7:0] max_iter_i;
  logic [Q*LW-1:0] chan_i;
  logic [DV*Q*LW-1:0] msg_i;
  logic [NC*DC*COLW-1:0] h_col_i;
  logic [NC*DC*3-1:0] h_coef_i;
  logic [NV*3-1:0] sym_o;
  logic iter_done_o, syn_zero_o, stop_o;
  logic [7:0] iter_cnt_o;

  always #10 clk = ~clk;

  gf8_hard_syndrome u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_iter_i(max_iter_i),
    .vn_valid_i(vn_valid_i), .chan_i(chan_i), .msg_i(msg_i),
    .h_col_i(h_col_i), .h_coef_i(h_coef_i), .sym_o(sym_o),
    .iter_done_o(iter_done_o), .syn_zero_o(syn_zero_o), .stop_o(stop_o),
    .iter_cnt_o(iter_cnt_o)
  );

  int n_chk = 0, n_bad = 0;
  int bch [NV][Q];
  int bm  [NV][DV][Q];
  int hcol[NC][DC];
  int hval[NC][DC];
  int exp_sym[NV];
  int exp_cnt = 0, max_it = 200;
  bit exp_stop = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    int p = 0;
    for (int i = 0; i < 3; i++) if (((b >> i) & 1) == 1) p = p ^ (a << i);
    for (int k = 4; k >= 3; k--) if (((p >> k) & 1) == 1) p = p ^ (11 << (k - 3));
    return p & 7;
  endfunction

  function automatic int possym(input int p);
    int s = 1;
    if (p == 0) return 0;
    for (int i = 1; i < p; i++) s = gmul(s, 2);
    return s;
  endfunction

  function automatic int model_pick(input int v);
    int bv = -1, bp = 0, pr;
    for (int k = 0; k < Q; k++) begin
      pr = bch[v][k];
      for (int d = 0; d < DV; d++) pr = pr * bm[v][d][k];
      if (pr > bv) begin bv = pr; bp = k; end
    end
    return possym(bp);
  endfunction

  function automatic int model_synzero();
    int acc;
    for (int r = 0; r < NC; r++) begin
      acc = 0;
      for (int j = 0; j < DC; j++) acc = acc ^ gmul(hval[r][j], exp_sym[hcol[r][j]]);
      if (acc != 0) return 0;
    end
    return 1;
  endfunction

  function automatic int rnd4();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return int'(lf[3:0]);
  endfunction

  task automatic drive_vn(input int v);
    for (int k = 0; k < Q; k++) begin
      chan_i[k*LW +: LW] = 4'(bch[v][k]);
      for (int d = 0; d < DV; d++) msg_i[(d*Q+k)*LW +: LW] = 4'(bm[v][d][k]);
    end
    vn_valid_i = 1'b1;
  endtask

  task automatic force_sym(input int v, input int s);
    int p = 0;
    for (int k = 0; k < Q; k++) if (possym(k) == s) p = k;
    for (int k = 0; k < Q; k++) begin
      bch[v][k] = (k == p) ? 9 : 1;
      for (int d = 0; d < DV; d++) bm[v][d][k] = 2;
    end
  endtask

  task automatic rand_vn(input int v);
    for (int k = 0; k < Q; k++) begin
      bch[v][k] = rnd4();
      for (int d = 0; d < DV; d++) bm[v][d][k] = rnd4();
    end
  endtask

  task automatic do_start(input int mx);
    @(negedge clk);
    max_iter_i = 8'(mx); max_it = mx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; exp_cnt = 0; exp_stop = 0;
  endtask

  task automatic do_iter(input string tag);
    int z;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_vn(v);
    end
    @(negedge clk);
    vn_valid_i = 1'b0;
    for (int v = 0; v < NV; v++) exp_sym[v] = model_pick(v);
    z = model_synzero();
    exp_cnt = (exp_cnt < 255) ? exp_cnt + 1 : 255;
    exp_stop = (z == 1) || (exp_cnt >= max_it);
    @(negedge clk);
    @(negedge clk);
    check({tag, " R7 no early done"}, int'(iter_done_o), 0);
    @(negedge clk);
    check({tag, " R7 done pulse"}, int'(iter_done_o), 1);
    check({tag, " R6 syn_zero"}, int'(syn_zero_o), z);
    check({tag, " R8 iter_cnt"}, int'(iter_cnt_o), exp_cnt);
    check({tag, " R8 stop"}, int'(stop_o), int'(exp_stop));
    for (int v = 0; v < NV; v++)
      check({tag, " R2/R4/R5 symbol"}, int'(sym_o[v*3 +: 3]), exp_sym[v]);
    @(negedge clk);
    check({tag, " R7 pulse ends"}, int'(iter_done_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0, s1, s2, snap;
    rst_n = 1'b0; start_i = 1'b0; vn_valid_i = 1'b0; max_iter_i = 8'd200;
    chan_i = '0; msg_i = '0;
    hcol[0] = '{0, 1, 2, 3}; hval[0] = '{1, 2, 3, 1};
    hcol[1] = '{0, 1, 2, 4}; hval[1] = '{4, 5, 0, 1};
    hcol[2] = '{1, 2, 0, 5}; hval[2] = '{7, 3, 6, 1};
    for (int r = 0; r < NC; r++)
      for (int j = 0; j < DC; j++) begin
        h_col_i[(r*DC+j)*COLW +: COLW] = 3'(hcol[r][j]);
        h_coef_i[(r*DC+j)*3 +: 3] = 3'(hval[r][j]);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 stop", int'(stop_o), 0);
    check("R1 iter_done", int'(iter_done_o), 0);
    check("R1 syn_zero", int'(syn_zero_o), 0);
    check("R1 iter_cnt", int'(iter_cnt_o), 0);
    check("R1 symbols", int'(sym_o), 0);

    // R1 / R10: strobes before any start are ignored
    force_sym(0, 5);
    drive_vn(0);
    repeat (3) @(negedge clk);
    vn_valid_i = 1'b0;
    check("R1 R10 ignored before start", int'(sym_o), 0);

    // random sweep over decisions and syndromes
    do_start(200);
    for (int it = 0; it < 40; it++) begin
      for (int v = 0; v < NV; v++) rand_vn(v);
      do_iter("random");
      if (exp_stop) do_start(200);
    end

    // R4 mapping sweep: every position wins on every node
    for (int p = 0; p < Q; p++) begin
      for (int v = 0; v < NV; v++) begin
        for (int k = 0; k < Q; k++) begin
          bch[v][k] = (k == (p + v) % Q) ? 12 : 1;
          for (int d = 0; d < DV; d++) bm[v][d][k] = 3;
        end
      end
      do_iter("R4 map");
      for (int v = 0; v < NV; v++)
        check("R4 literal map", int'(sym_o[v*3 +: 3]), possym((p + v) % Q));
      if (exp_stop) do_start(200);
    end

    // R3 ties
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < Q; k++) begin
        bch[v][k] = 1; bm[v][0][k] = 1; bm[v][1][k] = 1;
      end
    for (int k = 0; k < Q; k++) bch[0][k] = 5;
    bch[1][3] = 7; bch[1][5] = 7;
    bch[2][6] = 4; bch[2][7] = 4;
    for (int k = 0; k < Q; k++) bch[3][k] = 0;
    bch[4][2] = 4; bm[4][0][2] = 2; bch[4][4] = 2; bm[4][0][4] = 4;
    bch[5][1] = 3; bch[5][7] = 3;
    do_iter("R3 tie");
    check("R3 all equal -> symbol 0", int'(sym_o[0 +: 3]), 0);
    check("R3 pos3/pos5 -> symbol 4", int'(sym_o[3 +: 3]), 4);
    check("R3 pos6/pos7 -> symbol 7", int'(sym_o[6 +: 3]), 7);
    check("R3 all zero -> symbol 0", int'(sym_o[9 +: 3]), 0);
    check("R3 message tie -> symbol 2", int'(sym_o[12 +: 3]), 2);
    check("R3 pos1/pos7 -> symbol 1", int'(sym_o[15 +: 3]), 1);

    // R6 valid codewords stop at once
    for (int c = 0; c < 8; c++) begin
      do_start(200);
      s0 = c; s1 = (c * 3 + 1) % 8; s2 = (c * 5 + 2) % 8;
      force_sym(0, s0); force_sym(1, s1); force_sym(2, s2);
      force_sym(3, gmul(1, s0) ^ gmul(2, s1) ^ gmul(3, s2));
      force_sym(4, gmul(4, s0) ^ gmul(5, s1));
      force_sym(5, gmul(6, s0) ^ gmul(7, s1) ^ gmul(3, s2));
      do_iter("R6 codeword");
      check("R6 codeword syn_zero", int'(syn_zero_o), 1);
      check("R8 codeword stop", int'(stop_o), 1);
    end

    // R10 strobes while stopped are ignored
    snap = int'(sym_o);
    force_sym(0, 7);
    @(negedge clk);
    drive_vn(0);
    repeat (4) @(negedge clk);
    vn_valid_i = 1'b0;
    check("R10 ignored while stopped", int'(sym_o), snap);
    check("R10 no done while stopped", int'(iter_done_o), 0);

    // R8 iteration limit of 2 on a non-codeword
    do_start(2);
    for (int v = 0; v < NV; v++) force_sym(v, 1);
    do_iter("R8 limit first");
    check("R8 limit not yet", int'(stop_o), 0);
    do_iter("R8 limit second");
    check("R8 limit reached", int'(stop_o), 1);
    check("R8 limit count", int'(iter_cnt_o), 2);

    // R8 limit of 0 stops after one iteration
    do_start(0);
    do_iter("R8 zero limit");
    check("R8 zero limit stop", int'(stop_o), 1);

    // R9 start on the edge of the final row evaluation
    do_start(200);
    for (int v = 0; v < NV; v++) force_sym(v, 3);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_vn(v);
    end
    @(negedge clk);
    vn_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R9 aborted done", int'(iter_done_o), 0);
    check("R9 count cleared", int'(iter_cnt_o), 0);
    check("R9 stop cleared", int'(stop_o), 0);
    @(negedge clk);
    check("R9 no late done", int'(iter_done_o), 0);

    // R9 start with a coincident strobe: strobe ignored
    snap = int'(sym_o[0 +: 3]);
    force_sym(0, 6);
    drive_vn(0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; vn_valid_i = 1'b0;
    check("R9 coincident strobe ignored", int'(sym_o[0 +: 3]), snap);
    exp_cnt = 0; max_it = 200;

    // R10 strobes during row evaluation are ignored
    for (int v = 0; v < NV; v++) force_sym(v, (v + 2) % 8);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_vn(v);
    end
    @(negedge clk);
    chan_i = {4'hF, {7{4'h1}}};
    msg_i = {16{4'h1}};
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    vn_valid_i = 1'b0;
    check("R10 done despite strobes", int'(iter_done_o), 1);
    for (int v = 0; v < NV; v++)
      check("R10 symbol kept during eval", int'(sym_o[v*3 +: 3]), possym(0) == 0 ? model_pick(v) : 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule